// File: doc/BRIEF.md
# Cartridge PRG bank mapper

This block sits between an 8-bit CPU bus and an external program ROM on a game cartridge. It looks at the top bits of the 16-bit CPU address and chooses one of five 8 KB windows. The three high ROM windows always point at banks counted back from the end of the ROM. The low window at $6000-$7FFF points at whatever bank software last wrote into a single 8-bit register. A window of work RAM sits in the middle of the ROM space, at $C000-$DFFF. The block drives the ROM byte address as bank number over a 13-bit offset. It returns either the ROM byte, a RAM byte or zero on its read data port.

The bank register is loaded by a CPU write to exactly $6000. It can also be reloaded from a snapshot port, and its present value is always visible on that port. Saved state can therefore be brought back with no CPU cycles. The nametable mirroring output is a constant that the cartridge configuration chooses. The work RAM depth is a parameter. The full 8 KB window uses 13 address bits. With fewer address bits the RAM repeats across the window.

Top module: `prg_window_mapper`

## Requirements
- R1: With BANKS banks of 8 KB, CPU addresses $8000-$9FFF drive rom_addr = {BANKS-4, addr[12:0]}, and $A000-$BFFF drive rom_addr = {BANKS-3, addr[12:0]}. During a read, rd_data shows rom_data.
- R2: CPU addresses $E000-$FFFF drive rom_addr = {BANKS-1, addr[12:0]}, and a read returns rom_data.
- R3: CPU addresses $6000-$7FFF drive rom_addr = {bank register mod BANKS, addr[12:0]}. The output follows the address combinationally.
- R4: The bank register takes cpu_wdata at the clock edge only when cpu_wr is high and cpu_addr is exactly $6000. A write to any other address in $6000-$7FFF, for example $6001, $6800 or $7FFF, leaves it unchanged.
- R5: While reset is asserted, the bank register is 0, so $6000 reads come from bank 0. Reset is asserted asynchronously when rst_n goes low, and released two clock edges after rst_n rises.
- R6: CPU addresses $C000-$DFFF reach a work RAM at index addr[RAM_AW-1:0]. A write while cpu_wr is high is committed at the clock edge, and a read returns the stored byte combinationally. The RAM is not cleared by reset.
- R7: rd_data is 0 when cpu_rd is low, and also during a read of any address below $6000.
- R8: Writes to $8000-$BFFF, to $E000-$FFFF and to addresses below $6000 change neither the bank register nor the work RAM.
- R9: nt_mirror always equals the MIRROR_VERT parameter (1 = vertical).
- R10: snap_bank always shows the raw 8-bit bank register. When snap_load is high at a clock edge, the register takes snap_data, even if a CPU write to $6000 happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, committed at the clock edge |
| rd_data | output | 8 | Read data back to the CPU |
| rom_addr | output | 13+clog2(BANKS) | Byte address into the external program ROM |
| rom_data | input | 8 | Byte returned by the external ROM |
| nt_mirror | output | 1 | Constant nametable mirroring select |
| snap_load | input | 1 | Load the bank register from snap_data |
| snap_data | input | 8 | Snapshot value to restore |
| snap_bank | output | 8 | Present raw bank register value |

## Verification
The hardest cases to reach from the ports are the ones where the register must not change. These are writes that land one byte past the load address, or anywhere else in the switchable window. They also include a snapshot load and a CPU load on the same edge. For each of these, the bench first loads a known bank. It then applies the write that must be ignored, or the colliding pair. After that it reads the low window and snap_bank back before any other stimulus. The bench also steps through all 256 register values, so that the modulo wrap to an existing bank is covered for every value.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_SWAP = 3'd1,
    WIN_FIX0 = 3'd2,
    WIN_FIX1 = 3'd3,
    WIN_RAM  = 3'd4,
    WIN_FIX3 = 3'd5
  } win_e;

  localparam int unsigned OFF_W     = 13;
  localparam logic [15:0] LOAD_ADDR = 16'h6000;

  function automatic win_e decode_window(input logic [15:0] a);
    win_e w;
    unique case (a[15:13])
      3'd3:    w = WIN_SWAP;
      3'd4:    w = WIN_FIX0;
      3'd5:    w = WIN_FIX1;
      3'd6:    w = WIN_RAM;
      3'd7:    w = WIN_FIX3;
      default: w = WIN_NONE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mapper_addr_decode.sv
module mapper_addr_decode
  import mapper_pkg::*;
#(
  parameter int unsigned BANKS  = 16,
  parameter int unsigned BANK_W = 4
) (
  input  logic [15:0]       addr,
  input  logic [BANK_W-1:0] swap_bank,
  output win_e              win,
  output logic [BANK_W-1:0] rom_bank,
  output logic              load_hit
);

  localparam logic [BANK_W-1:0] BANK_FIX0 = BANK_W'(BANKS - 4);
  localparam logic [BANK_W-1:0] BANK_FIX1 = BANK_W'(BANKS - 3);
  localparam logic [BANK_W-1:0] BANK_FIX3 = BANK_W'(BANKS - 1);

  always_comb begin
    win      = decode_window(addr);
    load_hit = (addr == LOAD_ADDR);
    unique case (win)
      WIN_SWAP: rom_bank = swap_bank;
      WIN_FIX0: rom_bank = BANK_FIX0;
      WIN_FIX1: rom_bank = BANK_FIX1;
      WIN_FIX3: rom_bank = BANK_FIX3;
      default:  rom_bank = '0;
    endcase
  end

endmodule

// File: rtl/mapper_bank_reg.sv
module mapper_bank_reg #(
  parameter int unsigned BANKS  = 16,
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_ok,
  input  logic              cpu_load,
  input  logic [7:0]        cpu_data,
  input  logic              snap_load,
  input  logic [7:0]        snap_data,
  output logic [7:0]        bank_q,
  output logic [BANK_W-1:0] bank_eff
);

  localparam logic [8:0] MODV = 9'(BANKS);

  logic [7:0] bank_d;
  logic       bank_en;
  logic [8:0] wrapped;

  always_comb begin
    bank_en = snap_load | cpu_load;
    bank_d  = snap_load ? snap_data : cpu_data;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_d;
    end
  end

  always_comb begin
    wrapped  = {1'b0, bank_q} % MODV;
    bank_eff = wrapped[BANK_W-1:0];
  end

endmodule

// File: rtl/mapper_work_ram.sv
module mapper_work_ram #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned BANKS       = 16,
  parameter int unsigned RAM_AW      = 10,
  parameter logic        MIRROR_VERT = 1'b1,
  localparam int unsigned BANK_W     = $clog2(BANKS),
  localparam int unsigned ROM_AW     = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        rd_data,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              nt_mirror,
  input  logic              snap_load,
  input  logic [7:0]        snap_data,
  output logic [7:0]        snap_bank
);

  logic [1:0]        rst_sync;
  logic              rst_ok;
  win_e              win;
  logic [BANK_W-1:0] rom_bank;
  logic [BANK_W-1:0] swap_bank;
  logic              load_hit;
  logic              ram_we;
  logic [7:0]        ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ok = rst_sync[1];

  mapper_addr_decode #(.BANKS(BANKS), .BANK_W(BANK_W)) u_dec (
    .addr      (cpu_addr),
    .swap_bank (swap_bank),
    .win       (win),
    .rom_bank  (rom_bank),
    .load_hit  (load_hit)
  );

  mapper_bank_reg #(.BANKS(BANKS), .BANK_W(BANK_W)) u_bank (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .cpu_load  (cpu_wr & load_hit),
    .cpu_data  (cpu_wdata),
    .snap_load (snap_load),
    .snap_data (snap_data),
    .bank_q    (snap_bank),
    .bank_eff  (swap_bank)
  );

  assign ram_we = cpu_wr & (win == WIN_RAM);

  mapper_work_ram #(.AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (cpu_addr[RAM_AW-1:0]),
    .wdata (cpu_wdata),
    .rdata (ram_rdata)
  );

  assign rom_addr  = {rom_bank, cpu_addr[OFF_W-1:0]};
  assign nt_mirror = MIRROR_VERT;

  always_comb begin
    rd_data = 8'h00;
    if (cpu_rd) begin
      unique case (win)
        WIN_RAM:  rd_data = ram_rdata;
        WIN_NONE: rd_data = 8'h00;
        default:  rd_data = rom_data;
      endcase
    end
  end

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int unsigned BANKS  = 16,
  parameter int unsigned ROM_AW = 17
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        rd_data,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              snap_load,
  input logic [7:0]        snap_data,
  input logic [7:0]        snap_bank
);

  localparam int unsigned BW = ROM_AW - 13;

  p_fixed_low_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_addr[15:13] == 3'd4) |-> (rom_addr[ROM_AW-1:13] == BW'(BANKS - 4)));

  p_fixed_mid_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_addr[15:13] == 3'd5) |-> (rom_addr[ROM_AW-1:13] == BW'(BANKS - 3)));

  p_fixed_top_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_addr[15:13] == 3'd7) |-> (rom_addr[ROM_AW-1:13] == BW'(BANKS - 1)));

  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_addr[15:13] == 3'd3) |-> (rom_addr[12:0] == cpu_addr[12:0]));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!snap_load && !(cpu_wr && cpu_addr == 16'h6000)) |=> $stable(snap_bank));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!snap_load && cpu_wr && cpu_addr == 16'h6000) |=> (snap_bank == $past(cpu_wdata)));

  p_reset_r5: assert property (@(posedge clk)
    !rst_ok |-> (snap_bank == 8'h00));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !cpu_rd |-> (rd_data == 8'h00));

  p_outside_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_addr[15:13] < 3'd3) |-> (rd_data == 8'h00));

  p_snap_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    snap_load |=> (snap_bank == $past(snap_data)));

endmodule

bind prg_window_mapper mapper_checker #(.BANKS(BANKS), .ROM_AW(ROM_AW)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .rd_data   (rd_data),
  .rom_addr  (rom_addr),
  .snap_load (snap_load),
  .snap_data (snap_data),
  .snap_bank (snap_bank)
);

// File: tb/tb_prg_window_mapper.sv
module tb_prg_window_mapper;

  localparam int unsigned BANKS  = 16;
  localparam int unsigned RAM_AW = 10;
  localparam int unsigned BW     = $clog2(BANKS);
  localparam int unsigned ROM_AW = BW + 13;
  localparam time         CLK_P  = 10ns;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic [7:0]        cpu_wdata;
  logic              cpu_rd, cpu_wr;
  logic [7:0]        rd_data;
  logic [ROM_AW-1:0] rom_addr;
  logic [7:0]        rom_data;
  logic              nt_mirror;
  logic              snap_load;
  logic [7:0]        snap_data, snap_bank;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned cyc   = 0;

  always #(CLK_P/2) clk = ~clk;

  prg_window_mapper #(.BANKS(BANKS), .RAM_AW(RAM_AW), .MIRROR_VERT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rd_data(rd_data), .rom_addr(rom_addr),
    .rom_data(rom_data), .nt_mirror(nt_mirror), .snap_load(snap_load),
    .snap_data(snap_data), .snap_bank(snap_bank)
  );

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
    return {a[ROM_AW-1:13], 4'h0} ^ a[7:0];
  endfunction

  assign rom_data = rom_byte(rom_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic rd_rom(input string req, input logic [15:0] a, input int unsigned bank);
    logic [ROM_AW-1:0] ea;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    ea = {BW'(bank), a[12:0]};
    chk(req, 32'(rom_addr), 32'(ea));
    chk(req, 32'(rd_data), 32'(rom_byte(ea)));
    cpu_rd = 1'b0;
  endtask

  task automatic rd_val(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 chk(req, 32'(rd_data), 32'(exp));
    cpu_rd = 1'b0;
  endtask

  function automatic logic [7:0] ram_pat(input int unsigned i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    snap_load = 1'b0; snap_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R5 reset bank", 32'(snap_bank), 0);
    chk("R9 mirroring", 32'(nt_mirror), 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd_rom("R5 bank0 after reset", 16'h6000, 0);
    rd_rom("R5 bank0 after reset", 16'h7ABC, 0);

    // R1 / R2 fixed windows
    for (int off = 0; off < 16'h2000; off += 16'h0111) begin
      rd_rom("R1 window 8000", 16'h8000 + 16'(off), BANKS - 4);
      rd_rom("R1 window A000", 16'hA000 + 16'(off), BANKS - 3);
      rd_rom("R2 window E000", 16'hE000 + 16'(off), BANKS - 1);
    end
    rd_rom("R2 last byte", 16'hFFFF, BANKS - 1);

    // R3 all register values, wrapped modulo bank count
    for (int v = 0; v < 256; v++) begin
      wr(16'h6000, 8'(v));
      chk("R10 snap_bank shows register", 32'(snap_bank), 32'(v));
      rd_rom("R3 swap window", 16'h6000 + 16'((v * 37) & 16'h1FFF), v % BANKS);
      rd_rom("R1 fixed after load", 16'h8000, BANKS - 4);
    end

    // R4 near-miss writes
    wr(16'h6000, 8'd5);
    wr(16'h6001, 8'd10);
    rd_rom("R4 write 6001 ignored", 16'h6000, 5);
    wr(16'h7FFF, 8'd9);
    wr(16'h6800, 8'd3);
    chk("R4 register unchanged", 32'(snap_bank), 5);
    rd_rom("R4 window still bank5", 16'h7123, 5);

    // R6 work RAM sweep and aliasing
    for (int i = 0; i < (1 << RAM_AW); i++) wr(16'hC000 + 16'(i), ram_pat(i));
    for (int i = 0; i < (1 << RAM_AW); i++) begin
      rd_val("R6 ram readback", 16'hC000 + 16'(i), ram_pat(i));
      if ((i % 64) == 0) rd_val("R6 ram alias", 16'hD400 + 16'(i), ram_pat(i));
    end
    rd_val("R6 ram top", 16'hDFFF, ram_pat((1 << RAM_AW) - 1));
    rd_rom("R6 rom unaffected", 16'h8000, BANKS - 4);

    // R8 writes to ROM windows and low space
    wr(16'h8000, 8'hAA);
    wr(16'hA000, 8'h55);
    wr(16'hE000, 8'h11);
    wr(16'h0000, 8'h77);
    wr(16'h5FFF, 8'h66);
    chk("R8 register unchanged", 32'(snap_bank), 5);
    rd_val("R8 ram unchanged", 16'hC000, ram_pat(0));
    rd_val("R8 ram unchanged", 16'hDFFF, ram_pat((1 << RAM_AW) - 1));
    rd_rom("R8 rom 8000 unchanged", 16'h8000, BANKS - 4);

    // R7 outside reads and idle strobe
    for (int a = 0; a < 16'h6000; a += 16'h00F1) rd_val("R7 outside read", 16'(a), 8'h00);
    @(negedge clk);
    cpu_addr = 16'hE005; cpu_rd = 1'b0;
    #1 chk("R7 idle read", 32'(rd_data), 0);
    cpu_addr = 16'hC000;
    #1 chk("R7 idle ram read", 32'(rd_data), 0);

    // R10 snapshot restore, with collision
    @(negedge clk);
    snap_load = 1'b1; snap_data = 8'd9;
    cpu_addr = 16'h6000; cpu_wdata = 8'd3; cpu_wr = 1'b1;
    @(posedge clk);
    #1 snap_load = 1'b0; cpu_wr = 1'b0;
    chk("R10 restore wins", 32'(snap_bank), 9);
    rd_rom("R10 restored read", 16'h6000, 9);
    @(negedge clk);
    snap_load = 1'b1; snap_data = 8'hFE;
    @(posedge clk);
    #1 snap_load = 1'b0;
    rd_rom("R10 restored wrapped", 16'h6040, 8'hFE % BANKS);

    // R5 mid-run reset
    wr(16'h6000, 8'd7);
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R5 async clear", 32'(snap_bank), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd_rom("R5 bank0 after reset", 16'h6000, 0);
    rd_val("R6 ram kept over reset", 16'hC001, ram_pat(1));
    chk("R9 mirroring", 32'(nt_mirror), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule